// File: doc/BRIEF.md
# Paced Write Issue Sequencer

This block moves processor write transactions from a request queue onto a shared system bus. Each write takes one address cycle, followed by one to four data beats. The external agent paces the flow with an active-low ready input. A new write may start only if the agent showed ready two cycles before the start cycle. With single-beat writes this gives at most one write every two bus cycles.

Two enhanced modes set what happens when ready drops late.

- **Repeat mode** (`mode_pipe` = 0): the write counts only if ready is still asserted when its address cycle ends. If it is not, the same write is presented again later and the queue does not advance.
- **Pipelined mode** (`mode_pipe` = 1): every started write counts. After ready deasserts, exactly one extra write may start. Nothing more starts until ready is seen again with the two-cycle lead.

The data beats of a write can go out back to back. They can also be paced as pairs, with two idle bus cycles between pairs.

Top module: `wr_issue_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `valid_out` is 0, `sys_cmd` is 0 (idle), `sys_ad` is 0 and `wq_pop` is 0.
- R2: An address cycle starts in cycle t only if `wq_valid` is high and one of the following holds. Either `wr_rdy_n` was low in cycle t-2, or the pipelined spare described in R6 is available.
- R3: An address cycle drives `sys_cmd` = 1 and the request address on `sys_ad`. It is followed directly by the data beats. Beat i is taken from `wq_data[32*i +: 32]`, for i from 0 up to `wq_nbeats` (that field holds the beat count minus one). Beats use `sys_cmd` = 2, and the final beat uses `sys_cmd` = 3.
- R4: With single-beat writes and ready held low, address cycles repeat exactly every two cycles and never in adjacent cycles.
- R5: With `mode_pipe` = 0, a write is confirmed only if `wr_rdy_n` is low in its address cycle. An unconfirmed write leaves the queue unchanged. The next start therefore presents the same address and data again.
- R6: With `mode_pipe` = 1, every started write is confirmed. A start made while ready was seen two cycles earlier arms one spare start. That spare may be used once while ready is not seen. Using it disarms it.
- R7: With `mode_pipe` = 1, once the spare has been used, no write starts until `wr_rdy_n` is seen low with the two-cycle lead.
- R8: With `pat_gap` = 0, the data beats are back to back. With `pat_gap` = 1, two idle cycles follow every second beat, except after the final beat. For a four-beat write the `sys_cmd` sequence is 1,2,2,0,0,2,3.
- R9: `valid_out` is high exactly in address and data cycles. In all other cycles, including pattern gaps, `sys_cmd` = 0 and `sys_ad` = 0.
- R10: `wq_pop` is high for one cycle, in the final data beat of a confirmed write, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_pipe | input | 1 | 0 = repeat mode, 1 = pipelined mode |
| pat_gap | input | 1 | 0 = back-to-back beats, 1 = pairs with two-cycle gaps |
| wr_rdy_n | input | 1 | Active-low write ready from the external agent |
| wq_valid | input | 1 | Queue head holds a write |
| wq_addr | input | 32 | Queue head address |
| wq_data | input | 128 | Queue head data, beat i in bits 32*i+31..32*i |
| wq_nbeats | input | 2 | Queue head beat count minus one |
| wq_pop | output | 1 | Advance the queue after this cycle |
| sys_ad | output | 32 | Address/data bus |
| sys_cmd | output | 2 | Bus command: 0 idle, 1 write address, 2 data, 3 final data |
| valid_out | output | 1 | Bus carries a valid address or beat |

## Verification
The bench runs random segments and compares the bus against a cycle model on every cycle. Each segment mixes both modes, both pacing patterns, beat counts from one to four, and a ready signal that holds its level for random stretches. This exposes differences in the start decision, the confirm decision and the beat order.

Directed cases cover four situations:
- A dense stream of single-beat writes, which separates a two-cycle issue rate from a one-cycle rate.
- A ready pulse that lands exactly on an address cycle in repeat mode, which shows whether the write is repeated rather than dropped.
- A ready level held high in pipelined mode, which shows that exactly one spare write goes out, neither zero nor two.
- Four-beat writes under both patterns, which pin down the placement of the gap cycles.

// File: rtl/wr_issue_pkg.sv
package wr_issue_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_WADDR = 2'd1,
        CMD_WDATA = 2'd2,
        CMD_WLAST = 2'd3
    } wi_cmd_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_GAP  = 2'd2
    } wi_phase_e;

    // True when the beat just sent closes a group of pair_len beats.
    function automatic logic closes_group(input int unsigned beat_idx,
                                          input int unsigned pair_len);
        return ((beat_idx + 1) % pair_len) == 0;
    endfunction

endpackage

// File: rtl/wi_rdy_hist.sv
module wi_rdy_hist #(
    parameter int LEAD = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_rdy_n,
    output logic lead_ok
);
    logic [LEAD-1:0] hist_n;

    generate
        if (LEAD == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) hist_n <= '1;
                else     hist_n <= wr_rdy_n;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) hist_n <= '1;
                else     hist_n <= {hist_n[LEAD-2:0], wr_rdy_n};
            end
        end
    endgenerate

    assign lead_ok = !hist_n[LEAD-1];

    generate
        if (LEAD == 2) begin : g_chk
            // R2: the history tap reflects the ready input two cycles back
            p_lead_tap_r2: assert property (@(posedge clk) disable iff (rst)
                $past(!rst, 2) |-> (lead_ok == !$past(wr_rdy_n, 2)));
        end
    endgenerate
endmodule

// File: rtl/wi_issue_gate.sv
module wi_issue_gate (
    input  logic clk,
    input  logic rst,
    input  logic mode_pipe,
    input  logic wr_rdy_n,
    input  logic lead_ok,
    input  logic can_start,
    output logic go,
    output logic confirmed
);
    logic spare_q;

    assign go = can_start && (lead_ok || (mode_pipe && spare_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            spare_q   <= 1'b0;
            confirmed <= 1'b0;
        end else if (go) begin
            confirmed <= mode_pipe ? 1'b1 : !wr_rdy_n;
            spare_q   <= mode_pipe && lead_ok;
        end
    end

    // R7: a start without the ready lead consumes the spare
    p_spare_once_r7: assert property (@(posedge clk) disable iff (rst)
        (go && !lead_ok) |=> !spare_q);

    // R5: in repeat mode a late ready drop leaves the write unconfirmed
    p_repeat_late_r5: assert property (@(posedge clk) disable iff (rst)
        (go && !mode_pipe && wr_rdy_n) |=> !confirmed);
endmodule

// File: rtl/wr_issue_seq.sv
module wr_issue_seq
    import wr_issue_pkg::*;
#(
    parameter int DW        = 32,
    parameter int MAX_BEATS = 4,
    parameter int LEAD      = 2,
    parameter int PAIR_LEN  = 2,
    parameter int GAP_LEN   = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      mode_pipe,
    input  logic                      pat_gap,
    input  logic                      wr_rdy_n,
    input  logic                      wq_valid,
    input  logic [DW-1:0]             wq_addr,
    input  logic [MAX_BEATS*DW-1:0]   wq_data,
    input  logic [$clog2(MAX_BEATS)-1:0] wq_nbeats,
    output logic                      wq_pop,
    output logic [DW-1:0]             sys_ad,
    output logic [1:0]                sys_cmd,
    output logic                      valid_out
);
    localparam int NBW = $clog2(MAX_BEATS);
    localparam int GCW = (GAP_LEN > 1) ? $clog2(GAP_LEN) : 1;
    localparam logic [GCW-1:0] GAP_END = GCW'(GAP_LEN - 1);

    wi_phase_e      phase_q;
    logic [NBW-1:0] beat_q;
    logic [GCW-1:0] gap_q;
    logic           lead_ok, go, confirmed;
    logic           last_beat, group_end;
    wi_cmd_e        cmd;

    wi_rdy_hist #(.LEAD(LEAD)) u_hist (
        .clk(clk), .rst(rst), .wr_rdy_n(wr_rdy_n), .lead_ok(lead_ok)
    );

    wi_issue_gate u_gate (
        .clk(clk), .rst(rst), .mode_pipe(mode_pipe), .wr_rdy_n(wr_rdy_n),
        .lead_ok(lead_ok), .can_start(phase_q == PH_IDLE && wq_valid),
        .go(go), .confirmed(confirmed)
    );

    assign last_beat = (beat_q == wq_nbeats);
    assign group_end = closes_group(32'(beat_q), PAIR_LEN);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            beat_q  <= '0;
            gap_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: if (go) begin
                    phase_q <= PH_DATA;
                    beat_q  <= '0;
                end
                PH_DATA: begin
                    if (last_beat) begin
                        phase_q <= PH_IDLE;
                    end else begin
                        beat_q <= beat_q + 1'b1;
                        if (pat_gap && group_end) begin
                            phase_q <= PH_GAP;
                            gap_q   <= '0;
                        end
                    end
                end
                PH_GAP: begin
                    if (gap_q == GAP_END) phase_q <= PH_DATA;
                    else                  gap_q   <= gap_q + 1'b1;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd       = CMD_IDLE;
        sys_ad    = '0;
        valid_out = 1'b0;
        wq_pop    = 1'b0;
        case (phase_q)
            PH_IDLE: if (go) begin
                cmd       = CMD_WADDR;
                sys_ad    = wq_addr;
                valid_out = 1'b1;
            end
            PH_DATA: begin
                cmd       = last_beat ? CMD_WLAST : CMD_WDATA;
                sys_ad    = wq_data[beat_q*DW +: DW];
                valid_out = 1'b1;
                wq_pop    = last_beat && confirmed;
            end
            default: ;
        endcase
    end

    assign sys_cmd = cmd;

    // R4: two address cycles never sit next to each other
    p_addr_spacing_r4: assert property (@(posedge clk) disable iff (rst)
        (sys_cmd == CMD_WADDR) |=> (sys_cmd != CMD_WADDR));

    // R10: the queue advances only on a final beat
    p_pop_on_last_r10: assert property (@(posedge clk) disable iff (rst)
        wq_pop |-> (sys_cmd == CMD_WLAST));

    // R8: pattern gap cycles carry nothing
    p_gap_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_GAP) |-> (!valid_out && sys_ad == '0));

    // R3: every address cycle is followed by a data beat
    p_addr_then_data_r3: assert property (@(posedge clk) disable iff (rst)
        (sys_cmd == CMD_WADDR) |=> (sys_cmd == CMD_WDATA || sys_cmd == CMD_WLAST));

    generate
        if (LEAD == 2) begin : g_lead_chk
            // R2: repeat-mode starts need ready two cycles earlier
            p_start_lead_r2: assert property (@(posedge clk) disable iff (rst)
                (sys_cmd == CMD_WADDR && !mode_pipe) |-> $past(!wr_rdy_n, 2));
        end
    endgenerate
endmodule

// File: tb/wr_issue_seq_tb.sv
module wr_issue_seq_tb;
    localparam int CLK_NS = 4;

    logic clk = 0, rst = 1;
    logic mode_pipe = 0, pat_gap = 0, wr_rdy_n = 1, wq_valid = 0;
    logic [31:0] wq_addr = 0;
    logic [127:0] wq_data = 0;
    logic [1:0] wq_nbeats = 0;
    logic wq_pop, valid_out;
    logic [31:0] sys_ad;
    logic [1:0] sys_cmd;

    always #(CLK_NS/2) clk = ~clk;

    wr_issue_seq u_dut (
        .clk(clk), .rst(rst), .mode_pipe(mode_pipe), .pat_gap(pat_gap),
        .wr_rdy_n(wr_rdy_n), .wq_valid(wq_valid), .wq_addr(wq_addr),
        .wq_data(wq_data), .wq_nbeats(wq_nbeats), .wq_pop(wq_pop),
        .sys_ad(sys_ad), .sys_cmd(sys_cmd), .valid_out(valid_out)
    );

    int n_checks = 0, n_fail = 0;
    logic [31:0]  q_addr [256];
    logic [127:0] q_data [256];
    logic [1:0]   q_nb   [256];
    int q_head = 0, q_tail = 0;

    // model state
    int m_phase = 0, m_beat = 0, m_gap = 0;
    bit m_conf = 0, m_spare = 0, m_rd1 = 1, m_rd2 = 1;
    // observation counters for directed cases
    int o_addr = 0, o_pop = 0;
    logic [31:0] o_last_addr;
    int cmd_log [16];
    int cmd_n = 0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(logic [31:0] a, logic [1:0] nb);
        q_addr[q_tail % 256] = a;
        q_data[q_tail % 256] = {$urandom, $urandom, $urandom, $urandom};
        q_nb[q_tail % 256]   = nb;
        q_tail++;
    endtask

    function automatic bit exp_go();
        return (q_head != q_tail) && (!m_rd2 || (mode_pipe && m_spare));
    endfunction

    // one bus cycle: drive, compare with model, advance model at the edge
    task automatic step(logic rdy_n);
        bit go, last, e_valid, e_pop;
        logic [1:0] e_cmd;
        logic [31:0] e_ad;
        int hi;
        @(negedge clk);
        wr_rdy_n = rdy_n;
        hi = q_head % 256;
        wq_valid  = (q_head != q_tail);
        wq_addr   = wq_valid ? q_addr[hi] : 32'd0;
        wq_data   = wq_valid ? q_data[hi] : 128'd0;
        wq_nbeats = wq_valid ? q_nb[hi] : 2'd0;
        #1;
        go = 0; last = 0; e_valid = 0; e_pop = 0; e_cmd = 0; e_ad = 0;
        if (m_phase == 0) begin
            go = exp_go();
            if (go) begin e_valid = 1; e_cmd = 1; e_ad = q_addr[hi]; end
        end else if (m_phase == 1) begin
            last = (m_beat == int'(q_nb[hi]));
            e_valid = 1; e_cmd = last ? 2'd3 : 2'd2;
            e_ad = q_data[hi][m_beat*32 +: 32];
            e_pop = last && m_conf;
        end
        begin
            string t;
            t = (m_phase == 0) ? "R2" : (m_phase == 1) ? "R3" : "R8";
            check({t, " cmd"}, 32'(sys_cmd), 32'(e_cmd));
            check({t, " ad"}, sys_ad, e_ad);
            check("R9 valid_out", 32'(valid_out), 32'(e_valid));
            check("R10 pop", 32'(wq_pop), 32'(e_pop));
        end
        if (sys_cmd == 2'd1) begin o_addr++; o_last_addr = sys_ad; end
        if (wq_pop) o_pop++;
        if (cmd_n < 16) begin cmd_log[cmd_n] = int'(sys_cmd); cmd_n++; end
        @(posedge clk);
        if (m_phase == 0) begin
            if (go) begin
                m_phase = 1; m_beat = 0;
                m_conf  = mode_pipe ? 1'b1 : !rdy_n;
                m_spare = mode_pipe && !m_rd2;
            end
        end else if (m_phase == 1) begin
            if (last) m_phase = 0;
            else begin
                if (pat_gap && (m_beat % 2 == 1)) begin m_phase = 2; m_gap = 0; end
                m_beat++;
            end
        end else begin
            if (m_gap == 1) m_phase = 1; else m_gap++;
        end
        if (e_pop) q_head++;
        m_rd2 = m_rd1; m_rd1 = rdy_n;
    endtask

    task automatic drain();
        for (int i = 0; i < 200 && (q_head != q_tail || m_phase != 0); i++) step(1'b0);
    endtask

    task automatic clear_obs();
        o_addr = 0; o_pop = 0; cmd_n = 0;
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check("R1 valid_out", 32'(valid_out), 0);
        check("R1 cmd", 32'(sys_cmd), 0);
        check("R1 pop", 32'(wq_pop), 0);
        @(negedge clk); rst = 0;
        #1;
        check("R1 after release", 32'(valid_out), 0);
        @(posedge clk);

        // R4: dense single-beat stream in repeat mode
        mode_pipe = 0; pat_gap = 0;
        repeat (3) step(1'b0);
        for (int i = 0; i < 4; i++) push(32'h100 + i, 2'd0);
        clear_obs();
        repeat (8) step(1'b0);
        check("R4 addr count in 8 cycles", o_addr, 4);
        check("R4 pops in 8 cycles", o_pop, 4);
        check("R4 cycle pattern", {cmd_log[0], cmd_log[1], cmd_log[2]}, {32'd1, 32'd3, 32'd1});

        // R5: ready drops exactly in the address cycle
        drain(); repeat (3) step(1'b0);
        push(32'hABC0, 2'd0);
        clear_obs();
        step(1'b1); step(1'b1); step(1'b1);
        repeat (8) step(1'b0);
        check("R5 address presented twice", o_addr, 2);
        check("R5 single pop", o_pop, 1);
        check("R5 same address repeated", o_last_addr, 32'hABC0);

        // R6 / R7: pipelined spare with ready held high
        mode_pipe = 1;
        drain(); repeat (3) step(1'b0);
        push(32'h200, 2'd0); push(32'h201, 2'd0);
        repeat (6) step(1'b0);
        repeat (4) step(1'b1);
        for (int i = 0; i < 3; i++) push(32'h300 + i, 2'd0);
        clear_obs();
        repeat (20) step(1'b1);
        check("R6 exactly one spare write", o_addr, 1);
        check("R7 nothing more while ready high", o_pop, 1);
        clear_obs();
        repeat (10) step(1'b0);
        check("R7 resumes after ready returns", o_addr, 2);

        // R8: four-beat patterns
        mode_pipe = 0; drain(); repeat (3) step(1'b0);
        pat_gap = 1; push(32'h400, 2'd3); clear_obs();
        repeat (8) step(1'b0);
        check("R8 gapped sequence", {cmd_log[0], cmd_log[1], cmd_log[2], cmd_log[3],
              cmd_log[4], cmd_log[5], cmd_log[6]}, {32'd1, 32'd2, 32'd2, 32'd0, 32'd0, 32'd2, 32'd3});
        pat_gap = 0; drain(); repeat (3) step(1'b0);
        push(32'h500, 2'd3); clear_obs();
        repeat (6) step(1'b0);
        check("R8 back-to-back sequence", {cmd_log[0], cmd_log[1], cmd_log[2], cmd_log[3],
              cmd_log[4]}, {32'd1, 32'd2, 32'd2, 32'd2, 32'd3});

        // random segments, checked cycle by cycle against the model (R2 R3 R5 R6 R9 R10)
        for (int seg = 0; seg < 24; seg++) begin
            logic rl;
            int hold;
            drain();
            mode_pipe = $urandom % 2; pat_gap = $urandom % 2;
            rl = 0; hold = 0;
            for (int c = 0; c < 300; c++) begin
                if (hold == 0) begin rl = $urandom % 3 == 0; hold = 1 + $urandom % 6; end
                hold--;
                if ((q_tail - q_head) < 6 && ($urandom % 3 == 0))
                    push($urandom, 2'($urandom % 4));
                step(rl);
            end
        end
        drain();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule